// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block is the receiving end of a three-wire programming port: a serial clock, a serial data line and a latch strobe. All three pins are sampled by the on-chip system clock through two-stage synchronizers. Each rising edge seen on the serial clock pushes one data bit into a 22-bit shift register, most significant bit first. The shift register has no effect on the outputs by itself.

A rising edge on the latch strobe copies the upper 20 bits of the shift register into one of four configuration latches. The two bits received last pick the latch. The chosen latch raises its update output for exactly one system clock cycle, in the same cycle that its new contents appear. Serial clock edges that arrive while the strobe is high are discarded, so a host can leave the strobe high without disturbing the word it has loaded.

Top module: `ser3w_loader`

## Requirements
- R1: While reset is asserted, and after it is released until the first transfer, all four latch outputs read zero and all four update outputs are low.
- R2: Each synchronized rising edge of `ser_clk` with `ser_le` low shifts `ser_dat` into bit 0 of the 22-bit shift register. Only the last 22 bits received are kept: the first bit sent becomes bit 21 and the last becomes bit 0.
- R3: On a transfer, word bits [1:0] select the destination latch. Code 0 selects `if_ref_q`, code 1 selects `if_div_q`, code 2 selects `rf_ref_q` and code 3 selects `rf_div_q`. The latch receives word bits [21:2], with bit 21 as its MSB.
- R4: Shifting bits in without a rising edge on `ser_le` changes no latch output and raises no update output.
- R5: A latch that is not selected by a transfer keeps its value.
- R6: Rising edges of `ser_clk` seen while `ser_le` is high do not alter the shift register. A second transfer made afterwards therefore reloads the same word.
- R7: When the rising edges of `ser_clk` and `ser_le` are detected in the same system cycle, the transfer takes the word as it stood before that cycle, and the clock edge is discarded.
- R8: Each transfer drives the selected latch's update output high for exactly one system cycle. That cycle is the first one in which the new value is visible. No other update output rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock pin, asynchronous |
| ser_dat | input | 1 | Serial data pin, asynchronous |
| ser_le | input | 1 | Latch strobe pin, asynchronous |
| if_ref_q | output | 20 | IF reference divider latch |
| if_div_q | output | 20 | IF feedback divider latch |
| rf_ref_q | output | 20 | RF reference divider latch |
| rf_div_q | output | 20 | RF feedback divider latch |
| if_ref_upd | output | 1 | One-cycle update strobe for `if_ref_q` |
| if_div_upd | output | 1 | One-cycle update strobe for `if_div_q` |
| rf_ref_upd | output | 1 | One-cycle update strobe for `rf_ref_q` |
| rf_div_upd | output | 1 | One-cycle update strobe for `rf_div_q` |

## Verification
A serial clock rise and a latch strobe rise can be detected in the same system cycle, so a shift and a transfer compete for the same word. The bench provokes this by changing both pins on one system clock edge, with a data bit of one on the line. The word is chosen so that bit 0 of its selection code is zero. If the design shifts before it transfers, the word reaches a different latch, and the bench sees the wrong latch and the wrong strobe count. The bench also keeps the strobe high while it toggles the serial clock, then strobes a second time and expects the earlier word to be reloaded into the same latch.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;
  localparam int CTRL_W = 2;
  localparam int NUM_LATCH = 1 << CTRL_W;

  typedef enum logic [CTRL_W-1:0] {
    SEL_IF_REF = 2'd0,
    SEL_IF_DIV = 2'd1,
    SEL_RF_REF = 2'd2,
    SEL_RF_DIV = 2'd3
  } sel_e;
endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_n;

    always_comb begin
      chain_n = {chain_q[STAGES-2:0], d[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_n;
    end

    assign q[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/ser3w_edge.sv
module ser3w_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/ser3w_shifter.sv
module ser3w_shifter #(
  parameter int WORD_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] sr_n;

  always_comb begin
    sr_n = sr_q;
    if (shift_en) sr_n = {sr_q[WORD_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_n;
  end

  assign word = sr_q;
endmodule

// File: rtl/ser3w_latch_bank.sv
module ser3w_latch_bank
  import ser3w_pkg::*;
#(
  parameter int WORD_W = 22,
  localparam int PAY_W = WORD_W - CTRL_W
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 load,
  input  logic [WORD_W-1:0]                    word,
  output logic [NUM_LATCH-1:0][PAY_W-1:0]      lat,
  output logic [NUM_LATCH-1:0]                 upd
);
  logic [CTRL_W-1:0] sel;
  logic [PAY_W-1:0]  payload;

  assign sel     = word[CTRL_W-1:0];
  assign payload = word[WORD_W-1:CTRL_W];

  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_lat
    logic             hit;
    logic [PAY_W-1:0] val_q;
    logic [PAY_W-1:0] val_n;
    logic             upd_q;

    assign hit = load && (sel == CTRL_W'(i));

    always_comb begin
      val_n = val_q;
      if (hit) val_n = payload;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        upd_q <= 1'b0;
      end else begin
        val_q <= val_n;
        upd_q <= hit;
      end
    end

    assign lat[i] = val_q;
    assign upd[i] = upd_q;
  end
endmodule

// File: rtl/ser3w_loader.sv
module ser3w_loader
  import ser3w_pkg::*;
#(
  parameter int WORD_W      = 22,
  parameter int SYNC_STAGES = 2,
  localparam int PAY_W      = WORD_W - CTRL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_le,
  output logic [PAY_W-1:0] if_ref_q,
  output logic [PAY_W-1:0] if_div_q,
  output logic [PAY_W-1:0] rf_ref_q,
  output logic [PAY_W-1:0] rf_div_q,
  output logic             if_ref_upd,
  output logic             if_div_upd,
  output logic             rf_ref_upd,
  output logic             rf_div_upd
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // Pin synchronizers: bit 2 = le, bit 1 = data, bit 0 = clock.
  logic [2:0] pin_lvl;
  logic [1:0] pin_rise;
  logic       clk_rise;
  logic       le_rise;
  logic       le_lvl;
  logic       dat_lvl;

  ser3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_i_n),
    .d    ({ser_le, ser_dat, ser_clk}),
    .q    (pin_lvl)
  );

  assign le_lvl  = pin_lvl[2];
  assign dat_lvl = pin_lvl[1];

  ser3w_edge #(.W(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_i_n),
    .lvl  ({le_lvl, pin_lvl[0]}),
    .rise (pin_rise)
  );

  assign clk_rise = pin_rise[0];
  assign le_rise  = pin_rise[1];

  // A high strobe level blocks shifting, which also settles a collision.
  logic              shift_en;
  logic [WORD_W-1:0] shreg;

  assign shift_en = clk_rise && !le_lvl;

  ser3w_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .shift_en(shift_en),
    .din     (dat_lvl),
    .word    (shreg)
  );

  logic [NUM_LATCH-1:0][PAY_W-1:0] lat_all;
  logic [NUM_LATCH-1:0]            upd_all;

  ser3w_latch_bank #(.WORD_W(WORD_W)) u_bank (
    .clk  (clk),
    .rst_n(rst_i_n),
    .load (le_rise),
    .word (shreg),
    .lat  (lat_all),
    .upd  (upd_all)
  );

  assign if_ref_q   = lat_all[SEL_IF_REF];
  assign if_div_q   = lat_all[SEL_IF_DIV];
  assign rf_ref_q   = lat_all[SEL_RF_REF];
  assign rf_div_q   = lat_all[SEL_RF_DIV];
  assign if_ref_upd = upd_all[SEL_IF_REF];
  assign if_div_upd = upd_all[SEL_IF_DIV];
  assign rf_ref_upd = upd_all[SEL_RF_REF];
  assign rf_div_upd = upd_all[SEL_RF_DIV];
endmodule

// File: rtl/ser3w_loader_chk.sv
module ser3w_loader_chk
  import ser3w_pkg::*;
#(
  parameter int WORD_W = 22,
  localparam int PAY_W = WORD_W - CTRL_W
) (
  input logic                            clk,
  input logic                            rst_i_n,
  input logic                            le_lvl,
  input logic [WORD_W-1:0]               shreg,
  input logic [NUM_LATCH-1:0][PAY_W-1:0] lat_all,
  input logic [NUM_LATCH-1:0]            upd_all
);
  always @(posedge clk) begin
    if (!rst_i_n) begin
      a_r1_quiet_in_reset: assert (upd_all == '0 && lat_all == '0)
        else $error("R1: outputs active during reset");
    end
  end

  a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(upd_all));

  a_r6_no_shift_when_le: assert property (@(posedge clk) disable iff (!rst_i_n)
    le_lvl |=> $stable(shreg));

  for (genvar i = 0; i < NUM_LATCH; i++) begin : g_chk
    a_r8_pulse_once: assert property (@(posedge clk) disable iff (!rst_i_n)
      upd_all[i] |=> !upd_all[i]);

    a_r5_hold_unselected: assert property (@(posedge clk) disable iff (!rst_i_n)
      !upd_all[i] |-> $stable(lat_all[i]));

    a_r3_route_payload: assert property (@(posedge clk) disable iff (!rst_i_n)
      upd_all[i] |-> ($past(shreg[CTRL_W-1:0]) == CTRL_W'(i)) &&
                     (lat_all[i] == $past(shreg[WORD_W-1:CTRL_W])));
  end
endmodule

bind ser3w_loader ser3w_loader_chk #(.WORD_W(WORD_W)) u_chk (
  .clk    (clk),
  .rst_i_n(rst_i_n),
  .le_lvl (le_lvl),
  .shreg  (shreg),
  .lat_all(lat_all),
  .upd_all(upd_all)
);

// File: tb/sim_ser3w_loader.sv
`timescale 1ns/1ps
module sim_ser3w_loader;
  localparam int WORD_W = 22;
  localparam int PAY_W  = 20;
  localparam int HOLD   = 4;

  logic clk;
  logic rst_n;
  logic ser_clk, ser_dat, ser_le;
  logic [PAY_W-1:0] if_ref_q, if_div_q, rf_ref_q, rf_div_q;
  logic if_ref_upd, if_div_upd, rf_ref_upd, rf_div_upd;

  ser3w_loader #(.WORD_W(WORD_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .if_ref_q(if_ref_q), .if_div_q(if_div_q), .rf_ref_q(rf_ref_q), .rf_div_q(rf_div_q),
    .if_ref_upd(if_ref_upd), .if_div_upd(if_div_upd),
    .rf_ref_upd(rf_ref_upd), .rf_div_upd(rf_div_upd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [PAY_W-1:0] exp_val [4];
  int exp_cnt [4];
  int hi_cnt  [4];
  logic [3:0] upd_vec;
  logic [3:0] upd_prev;

  assign upd_vec = {rf_div_upd, rf_ref_upd, if_div_upd, if_ref_upd};

  // Count strobe-high cycles per latch, sampled away from the edge.
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) if (upd_vec[i]) hi_cnt[i] = hi_cnt[i] + 1;
  end

  function automatic logic [PAY_W-1:0] lat_of(int i);
    case (i)
      0: return if_ref_q;
      1: return if_div_q;
      2: return rf_ref_q;
      default: return rf_div_q;
    endcase
  endfunction

  task automatic check_eq(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < 4; i++) begin
      check_eq(req, lat_of(i), exp_val[i]);
      check_eq(req, hi_cnt[i], exp_cnt[i]);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    ser_dat = b;
    wait_n(HOLD);
    ser_clk = 1'b1;
    wait_n(HOLD);
    ser_clk = 1'b0;
  endtask

  task automatic send_word(logic [WORD_W-1:0] w);
    for (int i = WORD_W - 1; i >= 0; i--) send_bit(w[i]);
    wait_n(HOLD);
  endtask

  task automatic pulse_le();
    ser_le = 1'b1;
    wait_n(8);
    ser_le = 1'b0;
    wait_n(8);
  endtask

  task automatic expect_load(logic [WORD_W-1:0] w);
    exp_val[w[1:0]] = w[WORD_W-1:2];
    exp_cnt[w[1:0]] = exp_cnt[w[1:0]] + 1;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      exp_val[i] = '0; exp_cnt[i] = 0; hi_cnt[i] = 0;
    end
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_le = 1'b0;
    wait_n(5);
    // R1: reset state while held and after release
    check_all("R1 in reset");
    rst_n = 1'b1;
    wait_n(10);
    check_all("R1 after release");

    // R3 / R5 / R8 / R2: sweep all codes with several payload patterns
    for (int code = 0; code < 4; code++) begin
      for (int k = 0; k < 6; k++) begin
        logic [PAY_W-1:0] pay;
        logic [WORD_W-1:0] w;
        case (k)
          0: pay = '0;
          1: pay = '1;
          2: pay = 20'h80001;
          3: pay = 20'h55555 ^ PAY_W'(code);
          default: pay = PAY_W'((k * 32'h2F5A3) ^ (code * 32'h1111));
        endcase
        w = {pay, 2'(code)};
        send_word(w);
        pulse_le();
        expect_load(w);
        check_all("R3 R5 R8 sweep");
      end
    end

    // R2: leading surplus bits are pushed out
    begin
      logic [WORD_W-1:0] w;
      w = {20'hA5C3E, 2'd3};
      for (int i = 0; i < 7; i++) send_bit(1'b1);
      send_word(w);
      pulse_le();
      expect_load(w);
      check_all("R2 surplus bits");
    end

    // R4: shifting without the strobe changes nothing
    send_word({20'h12345, 2'd0});
    wait_n(10);
    check_all("R4 no strobe");

    // R6: clock edges while the strobe is high are dropped
    begin
      logic [WORD_W-1:0] w;
      w = {20'h3C3C3, 2'd1};
      send_word(w);
      ser_le = 1'b1;
      wait_n(8);
      for (int i = 0; i < 3; i++) begin
        send_bit(1'b1);
      end
      wait_n(HOLD);
      ser_le = 1'b0;
      wait_n(8);
      expect_load(w);
      check_all("R6 first load");
      pulse_le();
      expect_load(w);
      check_all("R6 reload same word");
    end

    // R7: strobe and clock rise in the same cycle
    begin
      logic [WORD_W-1:0] w;
      w = {20'h0F0F1, 2'd2};
      send_word(w);
      ser_dat = 1'b1;
      @(negedge clk);
      ser_clk = 1'b1;
      ser_le  = 1'b1;
      wait_n(8);
      ser_clk = 1'b0;
      ser_le  = 1'b0;
      wait_n(8);
      expect_load(w);
      check_all("R7 collision");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule